// File: doc/BRIEF.md
# Segmented Branch Target Generator

This block works out where instruction fetch goes next after a control-transfer instruction in a 16-bit processor that addresses memory as segment:offset. The decoder hands it one branch per strobe: the kind of transfer, the operand bytes that follow the opcode, the current code segment and instruction offset, the flag bits and the loop count register. One clock later the block presents the next segment and offset, a flag saying whether the transfer was taken, the 20-bit physical fetch address, the loop count after any decrement, and for calls and returns how many bytes an external stack unit must push or pop.

Three target encodings are handled: an 8-bit signed displacement, a 16-bit signed displacement, and an absolute segment:offset pair. Relative targets are measured from the offset of the following instruction, so the block adds the instruction length itself. Conditional branches test one flag each, and the count-and-branch form decrements the count and jumps while it stays nonzero. For returns the decoder places the value popped from the stack on the operand input, and the block turns it into the target.

Top module: `branch_target_gen`

## Requirements
- R1: Every cycle in which `in_valid` is high yields exactly one result, shown with `out_valid` high on the following cycle; `out_valid` is low in every other cycle.
- R2: Kind code 0 (2-byte short jump) is always taken: the next offset is `in_ip + 2` plus the sign-extended `in_imm[7:0]`, modulo 65536, and the segment stays `in_cs`.
- R3: Kind code 1 (3-byte near jump) is always taken: the next offset is `in_ip + 3 + in_imm[15:0]` modulo 65536, with no carry into the segment, which stays `in_cs`.
- R4: Kind code 2 (far jump) is always taken and loads the segment from `in_imm[31:16]` and the offset from `in_imm[15:0]`.
- R5: Kind code 3 is a 2-byte conditional branch. With `in_flags` bit 0 = carry, bit 1 = parity, bit 2 = zero, bit 3 = overflow, the condition codes are 0: zero set, 1: zero clear, 2: overflow clear, 3: parity set, 4: parity clear, 5: carry set. A true condition is taken to `in_ip + 2` plus the sign-extended `in_imm[7:0]`.
- R6: A conditional branch whose condition is false, or whose condition code is 6 or 7, is not taken and continues at `in_ip + 2` with the segment unchanged.
- R7: Kind code 4 (2-byte loop) outputs `in_cx - 1` modulo 65536 on `out_cx`; it is taken to `in_ip + 2` plus the sign-extended `in_imm[7:0]` when that result is nonzero and falls through to `in_ip + 2` when it is zero (so a count of 0 wraps to 65535 and is taken).
- R8: `out_phys` equals `out_cs * 16 + out_ip` modulo 2^20.
- R9: Kind code 5 (3-byte near call) targets `in_ip + 3 + in_imm[15:0]` and requests a push of 2 bytes; kind code 6 (far call) loads segment and offset as in R4 and requests a push of 4 bytes. Both are taken and drive `out_stack_push` high.
- R10: Kind code 7 (near return) takes the offset from `in_imm[15:0]`, keeps the segment and requests a pop of 2 bytes; kind code 8 (far return) takes the offset from `in_imm[15:0]` and the segment from `in_imm[31:16]` and requests a pop of 4 bytes. Both are taken and drive `out_stack_push` low.
- R11: `out_taken` is high only with `out_valid`; `out_cx` equals `in_cx` for every kind except the loop, and `out_stack_bytes` is 0 for every kind that is not a call or a return.
- R12: Kind codes 9 to 15 are not taken and continue at `in_ip + 1` with the segment unchanged.
- R13: After reset every output is 0 until the first result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | One-cycle strobe: a branch is presented |
| in_kind | input | 4 | Transfer kind code |
| in_cond | input | 3 | Condition code for kind 3 |
| in_flags | input | 4 | Flags: carry, parity, zero, overflow in bits 0..3 |
| in_imm | input | 32 | Operand bytes, or popped return address for returns |
| in_cs | input | 16 | Current code segment |
| in_ip | input | 16 | Offset of the branch instruction |
| in_cx | input | 16 | Current loop count |
| out_valid | output | 1 | Result present |
| out_taken | output | 1 | The transfer was taken |
| out_cs | output | 16 | Next code segment |
| out_ip | output | 16 | Next instruction offset |
| out_phys | output | 20 | Physical fetch address |
| out_cx | output | 16 | Loop count after the instruction |
| out_stack_bytes | output | 3 | Bytes to move on the stack (0, 2 or 4) |
| out_stack_push | output | 1 | High for push, low for pop |

## Verification
The assertions assume that the strobe and every input field are stable at the clock edge that captures them and that nothing drives `in_valid` while reset is high; the bench changes inputs only a step after a rising edge and keeps the strobe low through reset. They also take the loop count presented with a loop instruction as meaningful in all 65536 values, so the bench includes counts of 0 and 1 alongside ordinary ones. The bench places strobes one idle cycle apart, so each result can be matched to its request in order without assuming back-to-back throughput beyond what R1 states.

// File: rtl/bt_pkg.sv
package bt_pkg;

    localparam int WORD_W    = 16;
    localparam int SEG_SHIFT = 4;
    localparam int PHYS_W    = WORD_W + SEG_SHIFT;
    localparam int IMM_W     = 2 * WORD_W;
    localparam int DISP_S_W  = 8;
    localparam int LEN_W     = 3;
    localparam int STK_W     = 3;

    // Flag bit positions inside the flag input
    localparam int FL_C = 0;
    localparam int FL_P = 1;
    localparam int FL_Z = 2;
    localparam int FL_O = 3;
    localparam int FLAG_W = 4;

    typedef logic [WORD_W-1:0] word_t;
    typedef logic [PHYS_W-1:0] phys_t;

    typedef enum logic [3:0] {
        BK_SHORT     = 4'd0,
        BK_NEAR      = 4'd1,
        BK_FAR       = 4'd2,
        BK_COND      = 4'd3,
        BK_LOOP      = 4'd4,
        BK_CALL_NEAR = 4'd5,
        BK_CALL_FAR  = 4'd6,
        BK_RET_NEAR  = 4'd7,
        BK_RET_FAR   = 4'd8
    } kind_e;

    typedef enum logic [2:0] {
        CC_ZSET = 3'd0,
        CC_ZCLR = 3'd1,
        CC_OCLR = 3'd2,
        CC_PSET = 3'd3,
        CC_PCLR = 3'd4,
        CC_CSET = 3'd5
    } cond_e;

    typedef struct packed {
        logic             taken;
        word_t            cs;
        word_t            ip;
        word_t            cx;
        logic [STK_W-1:0] stk_bytes;
        logic             stk_push;
    } xfer_t;

    function automatic word_t sext_short(input logic [DISP_S_W-1:0] d);
        return {{(WORD_W-DISP_S_W){d[DISP_S_W-1]}}, d};
    endfunction

    // Encoded length in bytes of each transfer kind
    function automatic logic [LEN_W-1:0] inst_len(input kind_e k);
        case (k)
            BK_SHORT, BK_COND, BK_LOOP:  return LEN_W'(2);
            BK_NEAR, BK_CALL_NEAR:       return LEN_W'(3);
            BK_FAR, BK_CALL_FAR:         return LEN_W'(5);
            default:                     return LEN_W'(1);
        endcase
    endfunction

endpackage

// File: rtl/bt_cond_eval.sv
module bt_cond_eval
    import bt_pkg::*;
(
    input  logic [2:0]        cond,
    input  logic [FLAG_W-1:0] flags,
    output logic              hit
);
    always_comb begin
        case (cond_e'(cond))
            CC_ZSET: hit =  flags[FL_Z];
            CC_ZCLR: hit = ~flags[FL_Z];
            CC_OCLR: hit = ~flags[FL_O];
            CC_PSET: hit =  flags[FL_P];
            CC_PCLR: hit = ~flags[FL_P];
            CC_CSET: hit =  flags[FL_C];
            default: hit = 1'b0;
        endcase
    end
endmodule

// File: rtl/bt_phys_addr.sv
module bt_phys_addr #(
    parameter int OFF_W = 16,
    parameter int SHIFT = 4
) (
    input  logic [OFF_W-1:0]       seg,
    input  logic [OFF_W-1:0]       off,
    output logic [OFF_W+SHIFT-1:0] phys
);
    localparam int PW = OFF_W + SHIFT;

    logic [PW-1:0] seg_base;
    logic [PW-1:0] off_ext;

    generate
        if (SHIFT == 0) begin : g_flat
            assign seg_base = seg;
        end else begin : g_shift
            assign seg_base = {seg, {SHIFT{1'b0}}};
        end
    endgenerate

    assign off_ext = PW'(off);
    assign phys    = seg_base + off_ext;
endmodule

// File: rtl/bt_target_calc.sv
module bt_target_calc
    import bt_pkg::*;
(
    input  logic [3:0]       kind,
    input  logic             cond_hit,
    input  logic [IMM_W-1:0] imm,
    input  word_t            cs,
    input  word_t            ip,
    input  word_t            cx,
    output xfer_t            nxt
);
    kind_e k;
    word_t seq_ip;
    word_t rel_short;
    word_t rel_near;
    word_t cx_dec;
    word_t imm_off;
    word_t imm_seg;

    assign k         = kind_e'(kind);
    assign seq_ip    = ip + word_t'(inst_len(k));
    assign imm_off   = imm[WORD_W-1:0];
    assign imm_seg   = imm[IMM_W-1:WORD_W];
    assign rel_short = seq_ip + sext_short(imm[DISP_S_W-1:0]);
    assign rel_near  = seq_ip + imm_off;
    assign cx_dec    = cx - word_t'(1);

    always_comb begin
        nxt           = '0;
        nxt.cs        = cs;
        nxt.ip        = seq_ip;
        nxt.cx        = cx;
        case (k)
            BK_SHORT: begin
                nxt.taken = 1'b1;
                nxt.ip    = rel_short;
            end
            BK_NEAR: begin
                nxt.taken = 1'b1;
                nxt.ip    = rel_near;
            end
            BK_FAR: begin
                nxt.taken = 1'b1;
                nxt.cs    = imm_seg;
                nxt.ip    = imm_off;
            end
            BK_COND: begin
                nxt.taken = cond_hit;
                if (cond_hit) nxt.ip = rel_short;
            end
            BK_LOOP: begin
                nxt.cx    = cx_dec;
                nxt.taken = (cx_dec != '0);
                if (cx_dec != '0) nxt.ip = rel_short;
            end
            BK_CALL_NEAR: begin
                nxt.taken     = 1'b1;
                nxt.ip        = rel_near;
                nxt.stk_bytes = STK_W'(2);
                nxt.stk_push  = 1'b1;
            end
            BK_CALL_FAR: begin
                nxt.taken     = 1'b1;
                nxt.cs        = imm_seg;
                nxt.ip        = imm_off;
                nxt.stk_bytes = STK_W'(4);
                nxt.stk_push  = 1'b1;
            end
            BK_RET_NEAR: begin
                nxt.taken     = 1'b1;
                nxt.ip        = imm_off;
                nxt.stk_bytes = STK_W'(2);
            end
            BK_RET_FAR: begin
                nxt.taken     = 1'b1;
                nxt.cs        = imm_seg;
                nxt.ip        = imm_off;
                nxt.stk_bytes = STK_W'(4);
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/branch_target_gen.sv
module branch_target_gen
    import bt_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              in_valid,
    input  logic [3:0]        in_kind,
    input  logic [2:0]        in_cond,
    input  logic [FLAG_W-1:0] in_flags,
    input  logic [IMM_W-1:0]  in_imm,
    input  logic [WORD_W-1:0] in_cs,
    input  logic [WORD_W-1:0] in_ip,
    input  logic [WORD_W-1:0] in_cx,
    output logic              out_valid,
    output logic              out_taken,
    output logic [WORD_W-1:0] out_cs,
    output logic [WORD_W-1:0] out_ip,
    output logic [PHYS_W-1:0] out_phys,
    output logic [WORD_W-1:0] out_cx,
    output logic [STK_W-1:0]  out_stack_bytes,
    output logic              out_stack_push
);
    logic  cond_hit;
    xfer_t nxt;
    xfer_t res_q;
    logic  vld_q;

    bt_cond_eval u_cond (
        .cond  (in_cond),
        .flags (in_flags),
        .hit   (cond_hit)
    );

    bt_target_calc u_calc (
        .kind     (in_kind),
        .cond_hit (cond_hit),
        .imm      (in_imm),
        .cs       (in_cs),
        .ip       (in_ip),
        .cx       (in_cx),
        .nxt      (nxt)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            vld_q <= 1'b0;
            res_q <= '0;
        end else begin
            vld_q <= in_valid;
            if (in_valid) res_q <= nxt;
            else          res_q.taken <= 1'b0;
        end
    end

    bt_phys_addr #(
        .OFF_W (WORD_W),
        .SHIFT (SEG_SHIFT)
    ) u_phys (
        .seg  (res_q.cs),
        .off  (res_q.ip),
        .phys (out_phys)
    );

    assign out_valid       = vld_q;
    assign out_taken       = res_q.taken;
    assign out_cs          = res_q.cs;
    assign out_ip          = res_q.ip;
    assign out_cx          = res_q.cx;
    assign out_stack_bytes = res_q.stk_bytes;
    assign out_stack_push  = res_q.stk_push;
endmodule

// File: rtl/bt_checker.sv
module bt_checker
    import bt_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              in_valid,
    input logic [3:0]        in_kind,
    input logic [WORD_W-1:0] in_cs,
    input logic [WORD_W-1:0] in_ip,
    input logic [WORD_W-1:0] in_cx,
    input logic              out_valid,
    input logic              out_taken,
    input logic [WORD_W-1:0] out_cs,
    input logic [WORD_W-1:0] out_ip,
    input logic [WORD_W-1:0] out_cx,
    input logic [STK_W-1:0]  out_stack_bytes,
    input logic              out_stack_push
);
    a_r1_valid_latency: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> out_valid);

    a_r1_no_spurious: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> !out_valid);

    a_r11_taken_needs_valid: assert property (@(posedge clk) disable iff (rst)
        out_taken |-> out_valid);

    a_r11_cx_kept: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_kind != BK_LOOP) |=> out_cx == $past(in_cx));

    a_r2_short_keeps_cs: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_kind == BK_SHORT) |=> (out_taken && out_cs == $past(in_cs)));

    a_r7_loop_count: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_kind == BK_LOOP) |=> out_cx == WORD_W'($past(in_cx) - 16'd1));

    a_r7_loop_taken: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_kind == BK_LOOP && in_cx != 16'd1) |=> out_taken);

    a_r9_far_call_push: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_kind == BK_CALL_FAR) |=> (out_stack_bytes == 3'd4 && out_stack_push));

    a_r10_near_ret_pop: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_kind == BK_RET_NEAR) |=> (out_stack_bytes == 3'd2 && !out_stack_push));

    a_r12_unknown_kind: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_kind > 4'd8) |=>
            (!out_taken && out_cs == $past(in_cs) && out_ip == WORD_W'($past(in_ip) + 16'd1)));
endmodule

bind branch_target_gen bt_checker u_chk (
    .clk             (clk),
    .rst             (rst),
    .in_valid        (in_valid),
    .in_kind         (in_kind),
    .in_cs           (in_cs),
    .in_ip           (in_ip),
    .in_cx           (in_cx),
    .out_valid       (out_valid),
    .out_taken       (out_taken),
    .out_cs          (out_cs),
    .out_ip          (out_ip),
    .out_cx          (out_cx),
    .out_stack_bytes (out_stack_bytes),
    .out_stack_push  (out_stack_push)
);

// File: tb/branch_target_gen_tb.sv
module branch_target_gen_tb;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        in_valid = 1'b0;
    logic [3:0]  in_kind = '0;
    logic [2:0]  in_cond = '0;
    logic [3:0]  in_flags = '0;
    logic [31:0] in_imm = '0;
    logic [15:0] in_cs = '0;
    logic [15:0] in_ip = '0;
    logic [15:0] in_cx = '0;
    logic        out_valid;
    logic        out_taken;
    logic [15:0] out_cs;
    logic [15:0] out_ip;
    logic [19:0] out_phys;
    logic [15:0] out_cx;
    logic [2:0]  out_stack_bytes;
    logic        out_stack_push;

    int checks = 0;
    int failures = 0;

    typedef struct {
        logic        tk;
        logic [15:0] cs;
        logic [15:0] ip;
        logic [19:0] pa;
        logic [15:0] cx;
        logic [2:0]  sb;
        logic        sp;
        string       tag;
    } exp_t;

    exp_t sb_q[$];

    always #(CLK_PERIOD/2) clk = ~clk;

    branch_target_gen u_dut (
        .clk (clk), .rst (rst), .in_valid (in_valid), .in_kind (in_kind),
        .in_cond (in_cond), .in_flags (in_flags), .in_imm (in_imm),
        .in_cs (in_cs), .in_ip (in_ip), .in_cx (in_cx),
        .out_valid (out_valid), .out_taken (out_taken), .out_cs (out_cs),
        .out_ip (out_ip), .out_phys (out_phys), .out_cx (out_cx),
        .out_stack_bytes (out_stack_bytes), .out_stack_push (out_stack_push)
    );

    // Reference model written from the requirement list
    function automatic exp_t model(input logic [3:0] k, input logic [2:0] c,
                                   input logic [3:0] f, input logic [31:0] im,
                                   input logic [15:0] cs, input logic [15:0] ip,
                                   input logic [15:0] cx, input string tag);
        exp_t e;
        logic [15:0] s8;
        logic        cond_true;
        s8 = {{8{im[7]}}, im[7:0]};
        e.tk = 1'b1; e.cs = cs; e.cx = cx; e.sb = 3'd0; e.sp = 1'b0; e.tag = tag;
        e.ip = 16'(ip + 16'd1);
        cond_true = 1'b0;
        case (c)
            3'd0: cond_true = f[2];
            3'd1: cond_true = !f[2];
            3'd2: cond_true = !f[3];
            3'd3: cond_true = f[1];
            3'd4: cond_true = !f[1];
            3'd5: cond_true = f[0];
            default: cond_true = 1'b0;
        endcase
        if (k == 4'd0) e.ip = 16'(ip + 16'd2 + s8);
        else if (k == 4'd1 || k == 4'd5) e.ip = 16'(ip + 16'd3 + im[15:0]);
        else if (k == 4'd2 || k == 4'd6 || k == 4'd8) begin
            e.cs = im[31:16]; e.ip = im[15:0];
        end else if (k == 4'd7) e.ip = im[15:0];
        else if (k == 4'd3) begin
            e.tk = cond_true;
            e.ip = cond_true ? 16'(ip + 16'd2 + s8) : 16'(ip + 16'd2);
        end else if (k == 4'd4) begin
            e.cx = 16'(cx - 16'd1);
            e.tk = (e.cx != 16'd0);
            e.ip = e.tk ? 16'(ip + 16'd2 + s8) : 16'(ip + 16'd2);
        end else e.tk = 1'b0;
        if (k == 4'd5) begin e.sb = 3'd2; e.sp = 1'b1; end
        if (k == 4'd6) begin e.sb = 3'd4; e.sp = 1'b1; end
        if (k == 4'd7) e.sb = 3'd2;
        if (k == 4'd8) e.sb = 3'd4;
        e.pa = 20'({e.cs, 4'h0} + {4'h0, e.ip});
        return e;
    endfunction

    task automatic send(input logic [3:0] k, input logic [2:0] c, input logic [3:0] f,
                        input logic [31:0] im, input logic [15:0] cs,
                        input logic [15:0] ip, input logic [15:0] cx, input string tag);
        @(posedge clk); #1;
        in_kind = k; in_cond = c; in_flags = f; in_imm = im;
        in_cs = cs; in_ip = ip; in_cx = cx; in_valid = 1'b1;
        sb_q.push_back(model(k, c, f, im, cs, ip, cx, tag));
        @(posedge clk); #1;
        in_valid = 1'b0;
        @(negedge clk);
        checks++;
        if (out_valid !== 1'b1) begin
            failures++;
            $display("FAIL R1 result strobe: actual=%b expected=1", out_valid);
        end
    endtask

    // Monitor: pops expected items as results appear
    always @(negedge clk) begin
        if (!rst) begin
            if (out_taken && !out_valid) begin
                checks++; failures++;
                $display("FAIL R11 taken without valid: actual=1 expected=0");
            end
            if (out_valid) begin
                checks++;
                if (sb_q.size() == 0) begin
                    failures++;
                    $display("FAIL R1 unexpected result: actual=valid expected=idle");
                end else begin
                    exp_t e;
                    e = sb_q.pop_front();
                    if (out_taken !== e.tk || out_cs !== e.cs || out_ip !== e.ip ||
                        out_phys !== e.pa || out_cx !== e.cx ||
                        out_stack_bytes !== e.sb || out_stack_push !== e.sp) begin
                        failures++;
                        $display("FAIL %s: actual tk=%b %h:%h pa=%h cx=%h sb=%0d sp=%b expected tk=%b %h:%h pa=%h cx=%h sb=%0d sp=%b",
                                 e.tag, out_taken, out_cs, out_ip, out_phys, out_cx,
                                 out_stack_bytes, out_stack_push, e.tk, e.cs, e.ip,
                                 e.pa, e.cx, e.sb, e.sp);
                    end
                end
            end
        end
    end

    task automatic finish_run();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        failures++;
        $display("FAIL watchdog: actual=hung expected=done");
        finish_run();
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;
        @(negedge clk);
        checks++;
        if (out_valid !== 1'b0 || out_taken !== 1'b0 || out_cs !== 16'h0 ||
            out_ip !== 16'h0 || out_phys !== 20'h0 || out_cx !== 16'h0 ||
            out_stack_bytes !== 3'd0 || out_stack_push !== 1'b0) begin
            failures++;
            $display("FAIL R13 reset: actual v=%b tk=%b %h:%h expected all zero",
                     out_valid, out_taken, out_cs, out_ip);
        end

        // R2 short jumps
        send(4'd0, 3'd0, 4'h0, 32'h0000_0004, 16'h1000, 16'h0100, 16'h0007, "R2 short forward");
        send(4'd0, 3'd0, 4'h0, 32'h0000_0080, 16'h1000, 16'h0100, 16'h0007, "R2 short backward -128");
        send(4'd0, 3'd0, 4'h0, 32'h0000_0005, 16'h2222, 16'hFFFE, 16'h0007, "R2 short wrap");
        // R3 near jumps
        send(4'd1, 3'd0, 4'h0, 32'h0000_FFF0, 16'h1000, 16'h1000, 16'h0001, "R3 near backward");
        send(4'd1, 3'd0, 4'h0, 32'h0000_0020, 16'h3000, 16'hFFF0, 16'h0001, "R3 near wrap");
        // R4 / R8 far jumps
        send(4'd2, 3'd0, 4'h0, 32'hA300_0127, 16'h1000, 16'h0040, 16'h0002, "R4 far jump");
        send(4'd2, 3'd0, 4'h0, 32'hFFFF_FFFF, 16'h1000, 16'h0040, 16'h0002, "R8 phys wrap");
        // R5 conditions true: flags {O,Z,P,C}
        send(4'd3, 3'd0, 4'b0100, 32'h0000_0010, 16'h0500, 16'h0200, 16'h0, "R5 zero set taken");
        send(4'd3, 3'd1, 4'b0000, 32'h0000_00F0, 16'h0500, 16'h0200, 16'h0, "R5 zero clear taken");
        send(4'd3, 3'd2, 4'b0111, 32'h0000_0010, 16'h0500, 16'h0200, 16'h0, "R5 overflow clear taken");
        send(4'd3, 3'd3, 4'b0010, 32'h0000_0010, 16'h0500, 16'h0200, 16'h0, "R5 parity set taken");
        send(4'd3, 3'd4, 4'b1101, 32'h0000_0010, 16'h0500, 16'h0200, 16'h0, "R5 parity clear taken");
        send(4'd3, 3'd5, 4'b0001, 32'h0000_0010, 16'h0500, 16'h0200, 16'h0, "R5 carry set taken");
        // R6 conditions false
        send(4'd3, 3'd0, 4'b1011, 32'h0000_0010, 16'h0500, 16'h0200, 16'h0, "R6 zero set false");
        send(4'd3, 3'd2, 4'b1000, 32'h0000_0010, 16'h0500, 16'h0200, 16'h0, "R6 overflow clear false");
        send(4'd3, 3'd5, 4'b1110, 32'h0000_0010, 16'h0500, 16'h0200, 16'h0, "R6 carry set false");
        send(4'd3, 3'd6, 4'b1111, 32'h0000_0010, 16'h0500, 16'h0200, 16'h0, "R6 code 6 never");
        send(4'd3, 3'd7, 4'b0000, 32'h0000_0010, 16'h0500, 16'h0200, 16'h0, "R6 code 7 never");
        // R7 loop
        send(4'd4, 3'd0, 4'h0, 32'h0000_00FA, 16'h0600, 16'h0300, 16'h0005, "R7 loop taken");
        send(4'd4, 3'd0, 4'h0, 32'h0000_00FA, 16'h0600, 16'h0300, 16'h0001, "R7 loop falls through");
        send(4'd4, 3'd0, 4'h0, 32'h0000_00FA, 16'h0600, 16'h0300, 16'h0000, "R7 loop count 0 wraps");
        // R9 calls, R10 returns
        send(4'd5, 3'd0, 4'h0, 32'h0000_0100, 16'h0700, 16'h0010, 16'h0009, "R9 near call");
        send(4'd6, 3'd0, 4'h0, 32'h1234_5678, 16'h0700, 16'h0010, 16'h0009, "R9 far call");
        send(4'd7, 3'd0, 4'h0, 32'hDEAD_0013, 16'h0700, 16'h0400, 16'h0009, "R10 near return");
        send(4'd8, 3'd0, 4'h0, 32'hC83A_AC5E, 16'h0700, 16'h0400, 16'h0009, "R10 far return");
        // R12 unassigned kinds, R11 side outputs covered in every compare
        send(4'd9, 3'd0, 4'hF, 32'hFFFF_FFFF, 16'h0800, 16'hFFFF, 16'h0033, "R12 kind 9 sequential");
        send(4'd15, 3'd5, 4'hF, 32'h0000_0000, 16'h0800, 16'h0050, 16'h0033, "R12 kind 15 R11 quiet");

        repeat (3) @(posedge clk);
        checks++;
        if (sb_q.size() != 0) begin
            failures++;
            $display("FAIL R1 missing results: actual=%0d pending expected=0", sb_q.size());
        end
        finish_run();
    end
endmodule